// File: doc/BRIEF.md
# Region Trigger Order Log

This block keeps a circular log of region trigger events in the order they arrive. Each time the generation tracker reports the first access to a spatial region (a trigger), the log stores three things: the region number, the key used to look up the learned pattern, and the gap. The gap is the number of non-trigger accesses seen since the previous trigger. A small internal counter measures the gap. It counts non-trigger access pulses, saturates at its maximum, and clears on every trigger request.

When a cache miss occurs, the reconstruction engine asks the log for the most recent trigger of the missing region. A single-cycle parallel scan compares every live slot, with the newest slot given priority. The result is a found flag and a physical slot index. Through a combinational read port, the engine can then walk any slot by its index, using the write pointer and fill count to find the newest entry. An optional mode drops an append whose region, key and gap all equal those of a live entry.

Top module: `region_order_log`

## Requirements
- R1: After reset, fill_cnt and wr_ptr are 0, srch_done is 0, and every slot reads with rd_valid=0.
- R2: An accepted append writes region, key and gap into slot wr_ptr. At the next edge wr_ptr advances by one, wrapping from DEPTH-1 to 0, and fill_cnt grows by one.
- R3: The stored gap equals the number of acc_vld pulses since the previous app_vld, saturating at 2**DELTA_W-1. Every app_vld clears the count, including one that is dropped. An acc_vld in the same cycle as app_vld is not counted.
- R4: With fill_cnt equal to DEPTH, an append overwrites the oldest slot (the one at wr_ptr) and fill_cnt stays at DEPTH.
- R5: With dedup_en=1, an append whose region, key and gap all match a live slot is dropped. wr_ptr, fill_cnt and all slot contents stay unchanged.
- R6: With dedup_en=0, identical appends are all stored.
- R7: One cycle after srch_vld, srch_done is 1 for exactly one cycle. srch_found and srch_idx then name the newest live slot whose region equals srch_region. Newest means the slot at wr_ptr-1, then wr_ptr-2, and so on, wrapping modulo DEPTH.
- R8: A search with no matching live slot gives srch_found=0 and srch_idx=0.
- R9: A search issued in the same cycle as an append sees the contents from before that append.
- R10: rd_valid, rd_region, rd_key and rd_delta show slot rd_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dedup_en | input | 1 | Enables dropping of exact duplicates |
| acc_vld | input | 1 | Non-trigger access pulse |
| app_vld | input | 1 | Trigger append request |
| app_region | input | REG_W | Region number of the trigger |
| app_key | input | KEY_W | Pattern lookup key of the trigger |
| srch_vld | input | 1 | Search request |
| srch_region | input | REG_W | Region to search for |
| srch_done | output | 1 | Search result valid |
| srch_found | output | 1 | A match was found |
| srch_idx | output | IDX_W | Slot of the newest match |
| rd_idx | input | IDX_W | Slot to read |
| rd_valid | output | 1 | Slot holds an entry |
| rd_region | output | REG_W | Stored region |
| rd_key | output | KEY_W | Stored key |
| rd_delta | output | DELTA_W | Stored gap |
| fill_cnt | output | CNT_W | Number of live slots |
| wr_ptr | output | IDX_W | Next slot to be written |

## Verification
A wrong write pointer or fill count shows on wr_ptr and fill_cnt right after the append edge. It also shows in the next search as a hit on a stale or older slot. A faulty gap counter shows only in rd_delta of the next stored entry. Under dedup_en=1, the same fault also changes which later appends are dropped, so the bench compares every slot and every region search after each append against an arithmetic model.

// File: rtl/rmo_pkg.sv
package rmo_pkg;
  // Physical slot that lies k positions behind the newest written slot.
  function automatic int unsigned ring_back(input int unsigned wp,
                                            input int unsigned k,
                                            input int unsigned depth);
    return (wp + depth - 1 - (k % depth)) % depth;
  endfunction
endpackage

// File: rtl/rmo_gap_counter.sv
module rmo_gap_counter #(
  parameter int DELTA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_vld,
  input  logic               app_vld,
  output logic [DELTA_W-1:0] gap
);
  localparam logic [DELTA_W-1:0] GAP_MAX = {DELTA_W{1'b1}};

  logic [DELTA_W-1:0] gap_nxt;
  logic               gap_en;

  always_comb begin
    gap_en  = app_vld | (acc_vld & (gap != GAP_MAX));
    gap_nxt = app_vld ? '0 : gap + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap <= '0;
    else if (gap_en) gap <= gap_nxt;
  end

  // R3
  gap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_vld |=> gap == '0);
  // R3
  gap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !app_vld && gap != GAP_MAX) |=> gap == $past(gap) + 1'b1);
endmodule

// File: rtl/rmo_ring.sv
module rmo_ring #(
  parameter int DEPTH   = 8,
  parameter int REG_W   = 16,
  parameter int KEY_W   = 16,
  parameter int DELTA_W = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            dedup_en,
  input  logic                            app_vld,
  input  logic [REG_W-1:0]                app_region,
  input  logic [KEY_W-1:0]                app_key,
  input  logic [DELTA_W-1:0]              app_delta,
  output logic [DEPTH-1:0]                slot_vld,
  output logic [DEPTH-1:0][REG_W-1:0]     slot_region,
  output logic [DEPTH-1:0][KEY_W-1:0]     slot_key,
  output logic [DEPTH-1:0][DELTA_W-1:0]   slot_delta,
  output logic [IDX_W-1:0]                wptr,
  output logic [CNT_W-1:0]                cnt
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [DEPTH-1:0] same_hit;
  logic             dup_hit;
  logic             do_wr;
  logic [IDX_W-1:0] wptr_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel;
    assign same_hit[i] = slot_vld[i] && slot_region[i] == app_region &&
                         slot_key[i] == app_key && slot_delta[i] == app_delta;
    assign sel = do_wr && (wptr == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[i]    <= 1'b0;
        slot_region[i] <= '0;
        slot_key[i]    <= '0;
        slot_delta[i]  <= '0;
      end else if (sel) begin
        slot_vld[i]    <= 1'b1;
        slot_region[i] <= app_region;
        slot_key[i]    <= app_key;
        slot_delta[i]  <= app_delta;
      end
    end
  end

  always_comb begin
    dup_hit  = |same_hit;
    do_wr    = app_vld && !(dedup_en && dup_hit);
    wptr_nxt = (wptr == LAST_SLOT) ? '0 : wptr + 1'b1;
    cnt_nxt  = (cnt == FULL_CNT) ? cnt : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      cnt  <= '0;
    end else if (do_wr) begin
      wptr <= wptr_nxt;
      cnt  <= cnt_nxt;
    end
  end

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
  // R5
  dup_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (app_vld && dedup_en && dup_hit) |=> ($stable(wptr) && $stable(cnt)));
  // R2
  fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && cnt != FULL_CNT) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/rmo_scan.sv
module rmo_scan #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            slot_vld,
  input  logic [DEPTH-1:0][REG_W-1:0] slot_region,
  input  logic [IDX_W-1:0]            wptr,
  input  logic [CNT_W-1:0]            cnt,
  input  logic                        srch_vld,
  input  logic [REG_W-1:0]            srch_region,
  output logic                        srch_done,
  output logic                        srch_found,
  output logic [IDX_W-1:0]            srch_idx
);
  import rmo_pkg::*;

  logic             hit_nxt;
  logic [IDX_W-1:0] idx_nxt;

  // Oldest to newest, so the newest match is the last one assigned.
  always_comb begin
    hit_nxt = 1'b0;
    idx_nxt = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      logic [IDX_W-1:0] sl;
      sl = IDX_W'(ring_back(int'(wptr), k, DEPTH));
      if ((k < int'(cnt)) && slot_vld[sl] && slot_region[sl] == srch_region) begin
        hit_nxt = 1'b1;
        idx_nxt = sl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srch_done <= 1'b0;
    else        srch_done <= srch_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch_found <= 1'b0;
      srch_idx   <= '0;
    end else if (srch_vld) begin
      srch_found <= hit_nxt;
      srch_idx   <= hit_nxt ? idx_nxt : '0;
    end
  end

  // R7
  srch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_vld |=> srch_done);
  // R8
  miss_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && !srch_found) |-> srch_idx == '0);
  // R7
  hit_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && srch_found) |-> slot_vld[srch_idx]);
endmodule

// File: rtl/region_order_log.sv
module region_order_log #(
  parameter int DEPTH   = 8,
  parameter int REG_W   = 16,
  parameter int KEY_W   = 16,
  parameter int DELTA_W = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dedup_en,
  input  logic               acc_vld,
  input  logic               app_vld,
  input  logic [REG_W-1:0]   app_region,
  input  logic [KEY_W-1:0]   app_key,
  input  logic               srch_vld,
  input  logic [REG_W-1:0]   srch_region,
  output logic               srch_done,
  output logic               srch_found,
  output logic [IDX_W-1:0]   srch_idx,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [REG_W-1:0]   rd_region,
  output logic [KEY_W-1:0]   rd_key,
  output logic [DELTA_W-1:0] rd_delta,
  output logic [CNT_W-1:0]   fill_cnt,
  output logic [IDX_W-1:0]   wr_ptr
);
  logic [DELTA_W-1:0]              gap;
  logic [DEPTH-1:0]                slot_vld;
  logic [DEPTH-1:0][REG_W-1:0]     slot_region;
  logic [DEPTH-1:0][KEY_W-1:0]     slot_key;
  logic [DEPTH-1:0][DELTA_W-1:0]   slot_delta;

  rmo_gap_counter #(.DELTA_W(DELTA_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .app_vld(app_vld), .gap(gap)
  );

  rmo_ring #(.DEPTH(DEPTH), .REG_W(REG_W), .KEY_W(KEY_W), .DELTA_W(DELTA_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .dedup_en(dedup_en), .app_vld(app_vld),
    .app_region(app_region), .app_key(app_key), .app_delta(gap),
    .slot_vld(slot_vld), .slot_region(slot_region), .slot_key(slot_key),
    .slot_delta(slot_delta), .wptr(wr_ptr), .cnt(fill_cnt)
  );

  rmo_scan #(.DEPTH(DEPTH), .REG_W(REG_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_region(slot_region),
    .wptr(wr_ptr), .cnt(fill_cnt), .srch_vld(srch_vld), .srch_region(srch_region),
    .srch_done(srch_done), .srch_found(srch_found), .srch_idx(srch_idx)
  );

  // R10: combinational read port
  always_comb begin
    rd_valid  = 1'b0;
    rd_region = '0;
    rd_key    = '0;
    rd_delta  = '0;
    if (int'(rd_idx) < DEPTH) begin
      rd_valid  = slot_vld[rd_idx];
      rd_region = slot_region[rd_idx];
      rd_key    = slot_key[rd_idx];
      rd_delta  = slot_delta[rd_idx];
    end
  end
endmodule

// File: tb/region_order_log_tb.sv
module region_order_log_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int RW = 3;
  localparam int KW = 2;
  localparam int DW = 3;
  localparam int GMAX = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic dedup_en, acc_vld, app_vld, srch_vld;
  logic [RW-1:0] app_region, srch_region, rd_region;
  logic [KW-1:0] app_key, rd_key;
  logic srch_done, srch_found, rd_valid;
  logic [1:0] srch_idx, rd_idx, wr_ptr;
  logic [DW-1:0] rd_delta;
  logic [2:0] fill_cnt;

  int checks = 0;
  int errors = 0;
  int mreg[D], mkey[D], mdel[D], mv[D];
  int mcnt, mwp, mctr;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_order_log #(.DEPTH(D), .REG_W(RW), .KEY_W(KW), .DELTA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dedup_en(dedup_en), .acc_vld(acc_vld),
    .app_vld(app_vld), .app_region(app_region), .app_key(app_key),
    .srch_vld(srch_vld), .srch_region(srch_region), .srch_done(srch_done),
    .srch_found(srch_found), .srch_idx(srch_idx), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_region(rd_region), .rd_key(rd_key),
    .rd_delta(rd_delta), .fill_cnt(fill_cnt), .wr_ptr(wr_ptr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic model_reset();
    for (int s = 0; s < D; s++) begin mv[s] = 0; mreg[s] = 0; mkey[s] = 0; mdel[s] = 0; end
    mcnt = 0; mwp = 0; mctr = 0;
  endtask

  task automatic model_app(input int r, input int k);
    int dup = 0;
    int g = mctr;
    mctr = 0;
    for (int s = 0; s < D; s++)
      if (mv[s] != 0 && mreg[s] == r && mkey[s] == k && mdel[s] == g) dup = 1;
    if (!(dedup_en && dup != 0)) begin
      mv[mwp] = 1; mreg[mwp] = r; mkey[mwp] = k; mdel[mwp] = g;
      mwp = (mwp + 1) % D;
      if (mcnt < D) mcnt++;
    end
  endtask

  function automatic int model_find(input int r);
    for (int k = 0; k < mcnt; k++) begin
      int s = (mwp + D - 1 - k) % D;
      if (mv[s] != 0 && mreg[s] == r) return s;
    end
    return -1;
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " R2 fill_cnt"}, int'(fill_cnt), mcnt);
    chk({tag, " R2 wr_ptr"}, int'(wr_ptr), mwp);
    for (int s = 0; s < D; s++) begin
      rd_idx = 2'(s);
      #1;
      chk({tag, " R10 rd_valid"}, int'(rd_valid), mv[s]);
      if (mv[s] != 0) begin
        chk({tag, " R10 rd_region"}, int'(rd_region), mreg[s]);
        chk({tag, " R6 rd_key"}, int'(rd_key), mkey[s]);
        chk({tag, " R3 rd_delta"}, int'(rd_delta), mdel[s]);
      end
    end
  endtask

  task automatic do_acc(input int n);
    for (int i = 0; i < n; i++) begin
      acc_vld = 1'b1;
      tick();
      acc_vld = 1'b0;
      if (mctr < GMAX) mctr++;
    end
  endtask

  task automatic do_app(input int r, input int k, input string tag);
    app_vld = 1'b1; app_region = RW'(r); app_key = KW'(k);
    tick();
    app_vld = 1'b0;
    model_app(r, k);
    check_state(tag);
  endtask

  task automatic do_search(input int r, input string tag);
    int e;
    srch_vld = 1'b1; srch_region = RW'(r);
    tick();
    srch_vld = 1'b0;
    e = model_find(r);
    chk({tag, " R7 done"}, int'(srch_done), 1);
    chk({tag, " R7 found"}, int'(srch_found), (e >= 0) ? 1 : 0);
    chk({tag, " R8 idx"}, int'(srch_idx), (e >= 0) ? e : 0);
  endtask

  task automatic sweep(input int dd);
    dedup_en = dd[0];
    for (int i = 0; i < 24; i++) begin
      do_acc((i * 7) % 4);
      do_app((i * 3) % 5, (i / 2) % 2, "sweep R4");
      for (int r = 0; r < 8; r++) do_search(r, "sweep");
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dedup_en = 1'b0; acc_vld = 1'b0; app_vld = 1'b0; srch_vld = 1'b0;
    app_region = '0; app_key = '0; srch_region = '0; rd_idx = '0;
    apply_reset();
    // R1
    chk("R1 fill_cnt", int'(fill_cnt), 0);
    chk("R1 wr_ptr", int'(wr_ptr), 0);
    chk("R1 srch_done", int'(srch_done), 0);
    check_state("R1");

    // R8: empty log
    do_search(3, "R8 empty");
    tick();
    chk("R7 done pulse low", int'(srch_done), 0);

    // R3: saturation and simultaneous access
    do_acc(10);
    do_app(1, 1, "R3 sat");
    chk("R3 saturated gap", int'(rd_delta), 0); // placeholder slot check below
    rd_idx = 2'd0; #1;
    chk("R3 sat value", int'(rd_delta), GMAX);
    do_acc(2);
    acc_vld = 1'b1;
    do_app(2, 0, "R3 same-cycle");
    acc_vld = 1'b0;
    do_app(2, 0, "R3 cleared");

    // R9: search and append same cycle
    app_vld = 1'b1; app_region = 3'd6; app_key = 2'd3;
    srch_vld = 1'b1; srch_region = 3'd6;
    tick();
    app_vld = 1'b0; srch_vld = 1'b0;
    chk("R9 found before append", int'(srch_found), 0);
    model_app(6, 3);
    check_state("R9");
    do_search(6, "R9 after");

    // R6 and R4 with dedup off
    apply_reset();
    sweep(0);
    do_app(4, 2, "R6 dup a");
    do_app(4, 2, "R6 dup b");

    // R5 with dedup on
    apply_reset();
    dedup_en = 1'b1;
    do_app(5, 1, "R5 first");
    do_app(5, 1, "R5 second dropped");
    chk("R5 fill after drop", int'(fill_cnt), 1);
    do_acc(3);
    do_app(5, 1, "R5 new gap");
    sweep(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule